// File: doc/BRIEF.md
# PWM Channel Edge Comparator

This block forms one output channel of a pulse-width modulator. A shared 16-bit phase count, one step per PWM beat, is passed to every channel. Each channel compares that phase against two values of its own. The first is a phase offset that places the rising edge. The second is the duty cycle currently in force, which sets how long the pulse stays high after that edge. Both values are fractions of a cycle in units of 2^-16. Because the offset is subtracted from the phase modulo 2^16, a pulse that starts late in the cycle wraps past the cycle boundary without special handling.

A resolution setting `resSel` keeps only the top `resSel+1` bits of the phase, the offset and the duty. This matches the coarser slicing of the cycle that the shared timebase uses. The channel drives its inactive level in three cases: the channel is disabled, the phase counter is stopped, or the duty cycle is zero. The inactive level is low, or high when inversion is selected, so that inversion makes the output active-low. The output is registered. The timebase and the duty-cycle modulation are built elsewhere and feed this block.

Top module: `pwm_edge_chan`

## Requirements
- R1: While `rstN` is low, `pulseOut` is 0 at the next clock edge.
- R2: With both enables high and `invertEn` low, `pulseOut` is updated one clock after the inputs are sampled. It is 1 when ((phaseIn&M) - (delayIn&M)) mod 2^16 < (dutyIn&M), and 0 otherwise. M is the mask of the top `resSel+1` bits of a 16-bit word.
- R3: A pulse whose offset plus duty passes 2^16 wraps round. It is high from the offset up to the cycle end, and again from phase 0 up to (offset + duty) mod 2^16.
- R4: Bits of `phaseIn`, `delayIn` and `dutyIn` below the top `resSel+1` bits have no effect on `pulseOut`.
- R5: When `chanEn` is 0, `pulseOut` goes to the inactive level one clock later, whatever the phase and duty.
- R6: When `invertEn` is 1, `pulseOut` is the complement of the R2 result. The inactive level is then 1.
- R7: When `cntrEn` is 0, `pulseOut` holds the inactive level.
- R8: A masked duty of zero never produces an active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseIn | input | 16 | Shared phase count |
| delayIn | input | 16 | Rising-edge offset, units of 2^-16 cycle |
| dutyIn | input | 16 | Active duty cycle, units of 2^-16 cycle |
| resSel | input | 4 | Resolution; top resSel+1 bits are compared |
| chanEn | input | 1 | Channel enable |
| invertEn | input | 1 | Active-low output select |
| cntrEn | input | 1 | Phase counter running |
| pulseOut | output | 1 | Registered PWM output |

## Verification
The phase is swept in coarse steps across the whole cycle for several settings. One setting places a plain pulse at offset zero and one places a pulse that wraps past the cycle end; comparing them shows whether the modular subtraction is right. A sweep at low resolution, with awkward low-order bits in every operand, shows whether the masking is applied before the comparison. Further sweeps run with inversion, with the channel disabled, with the counter stopped and with zero duty, and show whether the inactive level follows the invert flag and not the phase.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int unsigned PHASE_W = 16;
  localparam int unsigned RES_W   = $clog2(PHASE_W);

  typedef struct packed {
    logic               run;   // channel and counter both enabled
    logic               inv;   // active-low selection
    logic [PHASE_W-1:0] mask;  // keeps top resSel+1 bits
  } edge_ctrl_t;
endpackage

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl
  import pwm_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] resSel,
  input  logic             chanEn,
  input  logic             cntrEn,
  input  logic             invertEn,
  output edge_ctrl_t       ctrl
);
  logic [PHASE_W-1:0] maskBits;

  // Bit i is kept when it lies within the top resSel+1 positions.
  for (genvar i = 0; i < PHASE_W; i++) begin : g_mask
    assign maskBits[i] = (i >= (PHASE_W - 1 - int'(resSel)));
  end

  always_comb begin
    ctrl.run  = chanEn & cntrEn;
    ctrl.inv  = invertEn;
    ctrl.mask = maskBits;
  end

  assert_mask_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctrl.mask) == int'(resSel) + 1);

  assert_mask_msb_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.mask[PHASE_W-1]);
endmodule

// File: rtl/pwm_edge_dp.sv
module pwm_edge_dp
  import pwm_edge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  edge_ctrl_t         ctrl,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [PHASE_W-1:0] delayIn,
  input  logic [PHASE_W-1:0] dutyIn,
  output logic               pulseOut
);
  logic [PHASE_W-1:0] phaseM, delayM, dutyM, relPhase;
  logic               inPulse, nextOut;

  always_comb begin
    phaseM   = phaseIn & ctrl.mask;
    delayM   = delayIn & ctrl.mask;
    dutyM    = dutyIn  & ctrl.mask;
    relPhase = phaseM - delayM;          // modulo 2^PHASE_W, covers wrap
    inPulse  = relPhase < dutyM;
    nextOut  = ctrl.run ? (inPulse ^ ctrl.inv) : ctrl.inv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pulseOut <= 1'b0;
    else       pulseOut <= nextOut;
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rstN |=> !pulseOut);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> pulseOut == $past(ctrl.inv));

  assert_zero_duty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dutyM == '0) |=> pulseOut == $past(ctrl.inv));

  assert_full_duty_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && (phaseM == delayM) && (dutyM != '0)) |=> pulseOut == !$past(ctrl.inv));
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
  import pwm_edge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [PHASE_W-1:0] delayIn,
  input  logic [PHASE_W-1:0] dutyIn,
  input  logic [RES_W-1:0]   resSel,
  input  logic               chanEn,
  input  logic               invertEn,
  input  logic               cntrEn,
  output logic               pulseOut
);
  edge_ctrl_t ctrl;

  pwm_edge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resSel(resSel), .chanEn(chanEn),
    .cntrEn(cntrEn), .invertEn(invertEn), .ctrl(ctrl)
  );

  pwm_edge_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .phaseIn(phaseIn),
    .delayIn(delayIn), .dutyIn(dutyIn), .pulseOut(pulseOut)
  );
endmodule

// File: tb/pwm_edge_chan_bench.sv
module pwm_edge_chan_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] phaseIn = '0, delayIn = '0, dutyIn = 16'h7FFF;
  logic [3:0]  resSel = 4'd15;
  logic        chanEn = 1'b0, invertEn = 1'b0, cntrEn = 1'b0;
  logic        pulseOut;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic expNext = 1'b0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  pwm_edge_chan u_pwm_edge_chan (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .delayIn(delayIn),
    .dutyIn(dutyIn), .resSel(resSel), .chanEn(chanEn),
    .invertEn(invertEn), .cntrEn(cntrEn), .pulseOut(pulseOut)
  );

  function automatic logic model(input logic [15:0] ph, dl, du,
                                 input int res, input logic ce, cn, iv, rn);
    int m, rel;
    if (!rn) return 1'b0;
    m   = 65536 - (1 << (15 - res));
    rel = ((ph & m) - (dl & m) + 65536) % 65536;
    if (!(ce && cn)) return iv;
    return (rel < (du & m)) ? !iv : iv;
  endfunction

  task automatic step();
    @(negedge clk);
    vectors++;
    if (pulseOut !== expNext) begin
      miscompares++;
      $display("FAIL %s: pulseOut=%0b expected=%0b (phase=%h delay=%h duty=%h res=%0d)",
               tag, pulseOut, expNext, phaseIn, delayIn, dutyIn, resSel);
    end
  endtask

  task automatic apply();
    expNext = model(phaseIn, delayIn, dutyIn, int'(resSel), chanEn, cntrEn, invertEn, rstN);
  endtask

  task automatic sweep(input string t, input logic [15:0] dl, du, input int res,
                       input logic ce, cn, iv);
    tag = t; delayIn = dl; dutyIn = du; resSel = res[3:0];
    chanEn = ce; cntrEn = cn; invertEn = iv;
    for (int p = 0; p < 65536; p += 257) begin
      phaseIn = p[15:0] ^ 16'h0011;
      apply();
      step();
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      phaseIn = 16'h1000 * k[15:0]; chanEn = 1'b1; cntrEn = 1'b1;
      apply();
      step();                                  // R1 reset holds output low
    end
    rstN = 1'b1;
    sweep("R2", 16'h0000, 16'h7FFF, 15, 1, 1, 0);
    sweep("R2", 16'h2000, 16'h1000, 15, 1, 1, 0);
    sweep("R3", 16'hC000, 16'h8000, 15, 1, 1, 0);
    sweep("R3", 16'hF000, 16'hFFFF, 15, 1, 1, 0);
    sweep("R4", 16'h1234, 16'h5678, 3, 1, 1, 0);
    sweep("R4", 16'h0FFF, 16'h8FFF, 0, 1, 1, 0);
    sweep("R4", 16'hA5A5, 16'h3C3C, 7, 1, 1, 0);
    sweep("R6", 16'h4000, 16'h6000, 15, 1, 1, 1);
    sweep("R5", 16'h0000, 16'h7FFF, 15, 0, 1, 0);
    sweep("R5", 16'h0000, 16'h7FFF, 15, 0, 1, 1);
    sweep("R7", 16'h0000, 16'hFFFF, 15, 1, 0, 0);
    sweep("R7", 16'h0000, 16'hFFFF, 15, 1, 0, 1);
    sweep("R8", 16'h0100, 16'h00FF, 7, 1, 1, 0);
    sweep("R8", 16'h0000, 16'h0000, 15, 1, 1, 1);
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule